// File: doc/BRIEF.md
# Accumulator Datapath With Ten-Code Instruction Decode

This block is the execute core of a very small accumulator machine. It has three registers: an accumulator, one general-purpose register and a registered output port. On every rising clock edge it runs the instruction on a 4-bit code input. The instruction can take a word from a parallel data input, move words between registers, or combine the accumulator with the general register in an arithmetic or logic unit.

Each register chooses its next value on its own, from the instruction code. The accumulator is loaded either from the data input or from the ALU. The general register is loaded either from the accumulator or from the data input. The output register copies either the general register or the accumulator. A register that the current code does not name keeps its contents. Codes outside the defined set change nothing.

Instruction fetch, sequencing, memory and status flags belong to the surrounding logic. The data width is a parameter and defaults to 8 bits.

Top module: `acc_datapath`

## Requirements
- R1: While rst_ni is low, acc_o, gpr_o and out_o are all zero. The reset is asynchronous.
- R2: Code 1 and code 6 both load acc_o from din_i on the next rising edge.
- R3: Code 2 loads gpr_o with the current acc_o. Code 5 loads gpr_o from din_i.
- R4: Code 3 loads out_o with the current gpr_o. Code 4 loads out_o with the current acc_o.
- R5: Code 7 sets acc_o to acc_o + gpr_o, wrapped modulo 2^WIDTH, and gives no carry output.
- R6: Code 8 sets acc_o to the bitwise OR of acc_o and gpr_o. Code 9 sets it to their bitwise AND.
- R7: Code 10 sets acc_o to the bitwise complement of acc_o.
- R8: gpr_o keeps its value under every code except 2 and 5.
- R9: acc_o keeps its value under codes 2, 3, 4 and 5.
- R10: out_o keeps its value under every code except 3 and 4.
- R11: Code 0 and codes 11 to 15 leave acc_o, gpr_o and out_o unchanged, whatever din_i carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all updates happen on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 4 | Instruction code for the current cycle |
| din_i | input | WIDTH | Parallel data input |
| acc_o | output | WIDTH | Accumulator contents |
| gpr_o | output | WIDTH | General register contents |
| out_o | output | WIDTH | Registered output port |

## Verification
The assertions assume that instr_i and din_i hold steady around each rising edge and carry known values whenever reset is released. They also assume that every 4-bit code is legal input, so the undefined codes are checked as no-operations and not ruled out. The stimulus changes the inputs only on the falling edge. It runs through every code 0 to 15, including operand values that overflow the adder and all-ones and all-zeros patterns. It then issues a long pseudo-random mix of codes and data, and asserts reset once in the middle of the run.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int unsigned CODE_W = 4;

  typedef enum logic [CODE_W-1:0] {
    OP_NOP     = 4'd0,
    OP_LD_A    = 4'd1,
    OP_MV_A2R  = 4'd2,
    OP_EMIT_R  = 4'd3,
    OP_EMIT_A  = 4'd4,
    OP_LD_R    = 4'd5,
    OP_LD_A_B  = 4'd6,
    OP_ADD     = 4'd7,
    OP_OR      = 4'd8,
    OP_AND     = 4'd9,
    OP_INV     = 4'd10
  } opcode_e;

  typedef enum logic [1:0] {ALU_ADD, ALU_OR, ALU_AND, ALU_INV} alu_op_e;
  typedef enum logic [1:0] {SRC_HOLD, SRC_DIN, SRC_ALU} acc_src_e;
  typedef enum logic [1:0] {GSRC_HOLD, GSRC_ACC, GSRC_DIN} gpr_src_e;
  typedef enum logic [1:0] {OSRC_HOLD, OSRC_GPR, OSRC_ACC} out_src_e;
endpackage

// File: rtl/acc_decode.sv
module acc_decode
  import acc_pkg::*;
(
  input  logic [CODE_W-1:0] instr_i,
  output acc_src_e          acc_src_o,
  output gpr_src_e          gpr_src_o,
  output out_src_e          out_src_o,
  output alu_op_e           alu_op_o
);
  always_comb begin
    acc_src_o = SRC_HOLD;
    gpr_src_o = GSRC_HOLD;
    out_src_o = OSRC_HOLD;
    alu_op_o  = ALU_ADD;
    case (instr_i)
      OP_LD_A, OP_LD_A_B: acc_src_o = SRC_DIN;
      OP_MV_A2R:          gpr_src_o = GSRC_ACC;
      OP_LD_R:            gpr_src_o = GSRC_DIN;
      OP_EMIT_R:          out_src_o = OSRC_GPR;
      OP_EMIT_A:          out_src_o = OSRC_ACC;
      OP_ADD: begin acc_src_o = SRC_ALU; alu_op_o = ALU_ADD; end
      OP_OR:  begin acc_src_o = SRC_ALU; alu_op_o = ALU_OR;  end
      OP_AND: begin acc_src_o = SRC_ALU; alu_op_o = ALU_AND; end
      OP_INV: begin acc_src_o = SRC_ALU; alu_op_o = ALU_INV; end
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  alu_op_e          op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] y_o
);
  always_comb begin
    unique case (op_i)
      ALU_ADD: y_o = a_i + b_i; // carry dropped
      ALU_OR:  y_o = a_i | b_i;
      ALU_AND: y_o = a_i & b_i;
      ALU_INV: y_o = ~a_i;
      default: y_o = a_i;
    endcase
  end
endmodule

// File: rtl/acc_reg.sv
module acc_reg #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] instr_i,
  input  logic [WIDTH-1:0]  din_i,
  output logic [WIDTH-1:0]  acc_o,
  output logic [WIDTH-1:0]  gpr_o,
  output logic [WIDTH-1:0]  out_o
);
  localparam int unsigned NREG = 3;

  acc_src_e acc_src;
  gpr_src_e gpr_src;
  out_src_e out_src;
  alu_op_e  alu_op;
  logic [WIDTH-1:0] alu_y;

  logic [NREG-1:0]            reg_en;
  logic [NREG-1:0][WIDTH-1:0] reg_d;
  logic [NREG-1:0][WIDTH-1:0] reg_q;

  acc_decode i_decode (
    .instr_i   (instr_i),
    .acc_src_o (acc_src),
    .gpr_src_o (gpr_src),
    .out_src_o (out_src),
    .alu_op_o  (alu_op)
  );

  acc_alu #(.WIDTH(WIDTH)) i_alu (
    .op_i (alu_op),
    .a_i  (reg_q[0]),
    .b_i  (reg_q[1]),
    .y_o  (alu_y)
  );

  // slot 0 = accumulator, 1 = general register, 2 = output
  always_comb begin
    reg_en[0] = (acc_src != SRC_HOLD);
    reg_d[0]  = (acc_src == SRC_DIN) ? din_i : alu_y;
    reg_en[1] = (gpr_src != GSRC_HOLD);
    reg_d[1]  = (gpr_src == GSRC_DIN) ? din_i : reg_q[0];
    reg_en[2] = (out_src != OSRC_HOLD);
    reg_d[2]  = (out_src == OSRC_GPR) ? reg_q[1] : reg_q[0];
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    acc_reg #(.WIDTH(WIDTH)) i_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (reg_en[g]),
      .d_i    (reg_d[g]),
      .q_o    (reg_q[g])
    );
  end

  assign acc_o = reg_q[0];
  assign gpr_o = reg_q[1];
  assign out_o = reg_q[2];

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_clear: assert (acc_o == '0 && gpr_o == '0 && out_o == '0);
    end
  end

  a_r2_load_din: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i == 4'd1 || instr_i == 4'd6) |=> acc_o == $past(din_i));
  a_r3_copy_acc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i == 4'd2) |=> gpr_o == $past(acc_o));
  a_r3_load_gpr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i == 4'd5) |=> gpr_o == $past(din_i));
  a_r4_emit_gpr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i == 4'd3) |=> out_o == $past(gpr_o));
  a_r4_emit_acc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i == 4'd4) |=> out_o == $past(acc_o));
  a_r5_add_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i == 4'd7) |=> acc_o == WIDTH'($past(acc_o) + $past(gpr_o)));
  a_r6_or: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i == 4'd8) |=> acc_o == ($past(acc_o) | $past(gpr_o)));
  a_r6_and: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i == 4'd9) |=> acc_o == ($past(acc_o) & $past(gpr_o)));
  a_r7_invert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i == 4'd10) |=> acc_o == ~$past(acc_o));
  a_r8_gpr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i != 4'd2 && instr_i != 4'd5) |=> $stable(gpr_o));
  a_r9_acc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i >= 4'd2 && instr_i <= 4'd5) |=> $stable(acc_o));
  a_r10_out_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i != 4'd3 && instr_i != 4'd4) |=> $stable(out_o));
  a_r11_nop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i == 4'd0 || instr_i >= 4'd11)
      |=> $stable(acc_o) && $stable(gpr_o) && $stable(out_o));
endmodule

// File: tb/test_acc_datapath.sv
module test_acc_datapath;
  localparam int W = 8;
  localparam int MAX_CYC = 100000;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [3:0]   instr_i = '0;
  logic [W-1:0] din_i = '0;
  logic [W-1:0] acc_o, gpr_o, out_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [W-1:0] m_acc = '0, m_gpr = '0, m_out = '0;

  always #4 clk_i = ~clk_i; // 125 MHz

  acc_datapath #(.WIDTH(W)) i_acc_datapath (
    .clk_i(clk_i), .rst_ni(rst_ni), .instr_i(instr_i), .din_i(din_i),
    .acc_o(acc_o), .gpr_o(gpr_o), .out_o(out_o)
  );

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > MAX_CYC) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected <= %0d", cycles, MAX_CYC);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string tag_acc(int c);
    if (c == 1 || c == 6) return "R2";
    if (c == 7) return "R5";
    if (c == 8 || c == 9) return "R6";
    if (c == 10) return "R7";
    if (c >= 2 && c <= 5) return "R9";
    return "R11";
  endfunction
  function automatic string tag_gpr(int c);
    if (c == 2 || c == 5) return "R3";
    if (c == 0 || c >= 11) return "R11";
    return "R8";
  endfunction
  function automatic string tag_out(int c);
    if (c == 3 || c == 4) return "R4";
    if (c == 0 || c >= 11) return "R11";
    return "R10";
  endfunction

  // inputs applied at negedge, model advances, compared at next negedge
  task automatic step(int code, logic [W-1:0] d);
    logic [W-1:0] na, ng, no;
    instr_i = code[3:0];
    din_i = d;
    na = m_acc; ng = m_gpr; no = m_out;
    case (code)
      1, 6: na = d;
      2:    ng = m_acc;
      5:    ng = d;
      3:    no = m_gpr;
      4:    no = m_acc;
      7:    na = W'(int'(m_acc) + int'(m_gpr));
      8:    na = m_acc | m_gpr;
      9:    na = m_acc & m_gpr;
      10:   na = ~m_acc;
      default: ;
    endcase
    @(posedge clk_i);
    @(negedge clk_i);
    m_acc = na; m_gpr = ng; m_out = no;
    chk(tag_acc(code), $sformatf("acc code %0d", code), acc_o, m_acc);
    chk(tag_gpr(code), $sformatf("gpr code %0d", code), gpr_o, m_gpr);
    chk(tag_out(code), $sformatf("out code %0d", code), out_o, m_out);
  endtask

  task automatic reset_check();
    rst_ni = 1'b0;
    #3;
    m_acc = '0; m_gpr = '0; m_out = '0;
    chk("R1", "acc reset", acc_o, '0);
    chk("R1", "gpr reset", gpr_o, '0);
    chk("R1", "out reset", out_o, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    @(negedge clk_i);
    reset_check();
    step(1, 8'hA5);  // R2
    step(2, 8'h00);  // R3 copy
    step(4, 8'h11);  // R4 emit acc
    step(6, 8'hF0);  // R2 second code
    step(7, 8'h00);  // R5 0xF0+0xA5 wraps
    step(3, 8'h00);  // R4 emit gpr
    step(5, 8'h3C);  // R3 load gpr
    step(8, 8'h00);  // R6 or
    step(9, 8'h00);  // R6 and
    step(10, 8'h00); // R7
    step(1, 8'hFF);
    step(5, 8'h01);
    step(7, 8'h00);  // R5 0xFF+1 -> 0
    step(4, 8'h00);
    for (int c = 0; c < 16; c++) step(c, 8'h5A); // every code, R8 R9 R10 R11
    for (int c = 11; c < 16; c++) step(c, 8'hFF); // R11
    step(0, 8'h77);
    for (int i = 0; i < 3000; i++) begin
      step(int'($urandom_range(0, 15)), W'($urandom));
      if (i == 1500) begin
        @(negedge clk_i);
        reset_check();
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule